// File: doc/BRIEF.md
# Cascaded Triangular-Window Smoothing Filter

This block smooths one stream of signed 14-bit sensor samples with a triangular (Bartlett-shaped) FIR window. The triangle comes from two identical moving-average stages in series. Each stage averages the last L = 2^M samples with a running sum and a circular delay line, then divides by L with an arithmetic right shift. No multipliers are needed. The combined response spans 2L−1 taps, and the weights rise linearly to a peak and then fall.

A 3-bit setting code picks M. A setting of zero collapses both stages to a single tap, so every sample passes through unchanged. A 3-bit measurement-range code sets a floor on M: the mid range needs at least 2 and the lowest range needs at least 4. A setting below that floor is raised to it. Whenever the resulting effective setting changes, the filter discards its history. It then stays silent until it has absorbed enough new samples to fill the whole window. One instance serves one channel. An upstream sampler feeds it a one-cycle valid strobe per sample, and a downstream register captures each filtered result.

Top module: `bartlett_filter`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` pulses for one cycle, exactly one clock after an accepted `in_valid`. It never rises without an `in_valid` in the cycle before.
- R3: With an effective setting of 0, every accepted sample appears unchanged on `out_data` one clock later, starting from the first sample after a clear.
- R4: With an effective setting M > 0 and L = 2^M, each stage computes the floor of the sum of its last L inputs divided by L. The second stage takes the first stage's results as its input. `out_data` carries the second stage's result for the newest sample.
- R5: After a clear, the first 2L−2 accepted samples give no `out_valid`. The sample numbered 2L−1 and every later one give a valid output.
- R6: Range code 3'b010 raises any setting below 2 to 2. Range code 3'b001 raises any setting below 4 to 4. Code 3'b100 and every other code leave the setting as programmed.
- R7: When the effective setting differs from the one in use, both stages are cleared and a sample offered in that same cycle is dropped. A range change that leaves the effective setting unchanged does not disturb the stream.
- R8: A constant full-scale input, either +8191 or −8192, is reproduced exactly on the output once the window is full, for every setting from 0 to 7. The running sums never overflow.
- R9: `out_data` holds its last value in every cycle where `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | One-cycle strobe marking a new sample |
| in_data | input | DW (14) | Signed input sample |
| set_code | input | 3 | Window setting M; L = 2^M per stage |
| range_code | input | 3 | Measurement-range code that sets the minimum M |
| out_valid | output | 1 | One-cycle strobe marking a filtered result |
| out_data | output | DW (14) | Signed filtered sample |

## Verification
The hardest conditions to reach from the ports are a setting change in the same cycle as a sample, and a range change that raises the floor while leaving the effective setting where it is. The stimulus brings a filter to its primed state first. It then switches the setting together with a strobe, or moves the range code from full to lowest while M is already 4. The bench's own floor-division model predicts whether the stream restarts or continues. The settings 5 to 7 need long primed runs of up to 255 samples. A full-scale sweep across all eight settings is the only way to fill the accumulators to their extremes.

// File: rtl/bwf_pkg.sv
// Shared constants and helpers for the triangular-window smoothing filter.
// Assumes range codes are one-hot when legal; any other code means no floor.
package bwf_pkg;
    localparam int CODE_W   = 3;
    localparam int N_STAGES = 2;

    localparam logic [CODE_W-1:0] RNG_FULL = 3'b100;
    localparam logic [CODE_W-1:0] RNG_MID  = 3'b010;
    localparam logic [CODE_W-1:0] RNG_LOW  = 3'b001;

    localparam logic [CODE_W-1:0] FLOOR_MID = 3'd2;
    localparam logic [CODE_W-1:0] FLOOR_LOW = 3'd4;

    // Minimum window setting demanded by a range code.
    function automatic logic [CODE_W-1:0] range_floor(input logic [CODE_W-1:0] rng);
        case (rng)
            RNG_MID: return FLOOR_MID;
            RNG_LOW: return FLOOR_LOW;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/bwf_setting_ctl.sv
// Derives the effective window setting from the programmed code and the
// range floor, capped at MAX_SET. Raises 'clear' combinationally in any
// cycle where the derived setting differs from the one in use; the new
// setting is adopted at that same edge.
module bwf_setting_ctl
    import bwf_pkg::*;
#(
    parameter int MAX_SET = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] set_code,
    input  logic [CODE_W-1:0] range_code,
    output logic [CODE_W-1:0] eff_q,
    output logic              clear
);
    localparam logic [CODE_W-1:0] CAP = CODE_W'(MAX_SET);

    logic [CODE_W-1:0] floor_v;
    logic [CODE_W-1:0] raised;
    logic [CODE_W-1:0] eff_next;

    // Apply range floor and cap, then compare with the setting in use.
    always_comb begin
        floor_v  = range_floor(range_code);
        raised   = (set_code < floor_v) ? floor_v : set_code;
        eff_next = (raised > CAP) ? CAP : raised;
        clear    = (eff_next != eff_q);
    end

    // Hold the effective setting.
    always_ff @(posedge clk) begin
        if (!rst_n) eff_q <= '0;
        else        eff_q <= eff_next;
    end
endmodule

// File: rtl/bwf_boxcar.sv
// One moving-average stage of length 2^shift. A circular delay line of
// 2^MAX_SET entries holds past inputs; only the first 2^shift are used.
// 'avg' is combinational and already includes 'din', so two stages in
// series add no latency. Assumes MAX_SET >= 1 and that 'clear' is raised
// whenever 'shift' changes.
module bwf_boxcar #(
    parameter int DW      = 14,
    parameter int MAX_SET = 7,
    parameter int ACC_W   = DW + MAX_SET + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    advance,
    input  logic [2:0]              shift,
    input  logic signed [DW-1:0]    din,
    output logic signed [DW-1:0]    avg,
    output logic signed [ACC_W-1:0] sum_q
);
    localparam int PW    = MAX_SET;
    localparam int DEPTH = 1 << MAX_SET;

    logic signed [DW-1:0]    line [DEPTH];
    logic [PW-1:0]           ptr_q;
    logic [PW-1:0]           mask;
    logic signed [DW-1:0]    oldest;
    logic signed [ACC_W-1:0] sum_new;
    logic signed [ACC_W-1:0] scaled;

    // Window arithmetic: add newest, drop oldest, divide by shifting.
    always_comb begin
        mask    = PW'((1 << shift) - 1);
        oldest  = line[ptr_q];
        sum_new = sum_q + ACC_W'(din) - ACC_W'(oldest);
        scaled  = sum_new >>> shift;
        avg     = scaled[DW-1:0];
    end

    // Delay line, pointer and running sum.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            for (int i = 0; i < DEPTH; i++) line[i] <= '0;
            ptr_q <= '0;
            sum_q <= '0;
        end else if (advance) begin
            line[ptr_q] <= din;
            sum_q       <= sum_new;
            ptr_q       <= (ptr_q + PW'(1)) & mask;
        end
    end
endmodule

// File: rtl/bartlett_filter.sv
// Triangular-window smoothing filter for one channel: two moving-average
// stages in series, length 2^M each, with a range-dependent floor on M.
// Output is registered one clock after each accepted input once 2L-1
// samples have been absorbed since the last clear.
module bartlett_filter
    import bwf_pkg::*;
#(
    parameter int DW      = 14,
    parameter int MAX_SET = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_data,
    input  logic [2:0]           set_code,
    input  logic [2:0]           range_code,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_data
);
    localparam int ACC_W = DW + MAX_SET + 1;
    localparam int CNT_W = MAX_SET + 2;

    logic [CODE_W-1:0]       eff_q;
    logic                    clear;
    logic                    accept;
    logic signed [DW-1:0]    stage_in  [N_STAGES];
    logic signed [DW-1:0]    stage_avg [N_STAGES];
    logic signed [ACC_W-1:0] stage_sum [N_STAGES];
    logic signed [ACC_W-1:0] sum_first;
    logic signed [ACC_W-1:0] sum_last;
    logic [CNT_W-1:0]        cnt_q;
    logic [CNT_W-1:0]        cnt_inc;
    logic [CNT_W-1:0]        target;
    logic                    primed;

    bwf_setting_ctl #(.MAX_SET(MAX_SET)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_code   (set_code),
        .range_code (range_code),
        .eff_q      (eff_q),
        .clear      (clear)
    );

    assign accept = in_valid && !clear;

    for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_head
            assign stage_in[g] = in_data;
        end else begin : g_tail
            assign stage_in[g] = stage_avg[g-1];
        end
        bwf_boxcar #(.DW(DW), .MAX_SET(MAX_SET), .ACC_W(ACC_W)) u_box (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (clear),
            .advance (accept),
            .shift   (eff_q),
            .din     (stage_in[g]),
            .avg     (stage_avg[g]),
            .sum_q   (stage_sum[g])
        );
    end

    assign sum_first = stage_sum[0];
    assign sum_last  = stage_sum[N_STAGES-1];

    // Priming threshold: the window holds 2L-1 taps.
    always_comb begin
        target  = CNT_W'((2 << eff_q) - 1);
        cnt_inc = cnt_q + CNT_W'(1);
        primed  = (cnt_inc >= target);
    end

    // Count absorbed samples since the last clear, saturating at target.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)                 cnt_q <= '0;
        else if (accept && cnt_q != target)  cnt_q <= cnt_inc;
    end

    // Output register and valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= accept && primed;
            if (accept && primed) out_data <= stage_avg[N_STAGES-1];
        end
    end
endmodule

// File: rtl/bwf_checker.sv
// Temporal checks for bartlett_filter, attached by bind below.
module bwf_checker #(
    parameter int DW      = 14,
    parameter int MAX_SET = 7,
    parameter int ACC_W   = DW + MAX_SET + 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic signed [DW-1:0]    in_data,
    input logic [2:0]              range_code,
    input logic                    out_valid,
    input logic signed [DW-1:0]    out_data,
    input logic                    clear,
    input logic [2:0]              eff_q,
    input logic signed [ACC_W-1:0] sum_first,
    input logic signed [ACC_W-1:0] sum_last
);
    localparam int LOW_MIN = (MAX_SET < 4) ? MAX_SET : 4;
    localparam int MID_MIN = (MAX_SET < 2) ? MAX_SET : 2;

    longint hi_l;
    longint lo_l;

    // Legal span of a stage sum for the setting in use.
    always_comb begin
        hi_l = ((longint'(1) << (DW-1)) - 1) << eff_q;
        lo_l = -((longint'(1) << (DW-1)) << eff_q);
    end

    a_r2_valid_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    a_r3_bypass_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(eff_q) == 3'd0 && !$past(clear)) |-> (out_data == $past(in_data)));

    a_r6_low_range_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (range_code == 3'b001) |=> (int'(eff_q) >= LOW_MIN));

    a_r6_mid_range_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (range_code == 3'b010) |=> (int'(eff_q) >= MID_MIN));

    a_r7_clear_silences: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !out_valid);

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (longint'(sum_first) <= hi_l) && (longint'(sum_first) >= lo_l) &&
        (longint'(sum_last) <= hi_l) && (longint'(sum_last) >= lo_l));

    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));
endmodule

bind bartlett_filter bwf_checker #(.DW(DW), .MAX_SET(MAX_SET)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .range_code (range_code),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .clear      (clear),
    .eff_q      (eff_q),
    .sum_first  (sum_first),
    .sum_last   (sum_last)
);

// File: tb/bartlett_filter_bench.sv
// Self-checking bench: sweeps every setting and range code against an
// arithmetic floor-division model of two cascaded averages.
module bartlett_filter_bench;
    localparam int DW = 14;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_data = '0;
    logic [2:0]           set_code = 3'd0;
    logic [2:0]           range_code = 3'b100;
    logic                 out_valid;
    logic signed [DW-1:0] out_data;

    int n_tests = 0;
    int n_fail  = 0;
    int hist [0:1023];
    int nh = 0;
    int cur_eff = 0;
    int last_out = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    bartlett_filter #(.DW(DW), .MAX_SET(7)) u_bartlett_filter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .set_code(set_code), .range_code(range_code),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic int fdiv(int s, int l);
        int q = s / l;
        if ((s % l) != 0 && s < 0) q = q - 1;
        return q;
    endfunction

    function automatic int eff_of(int s, int r);
        int f = (r == 2) ? 2 : ((r == 1) ? 4 : 0);
        int e = (s < f) ? f : s;
        return (e > 7) ? 7 : e;
    endfunction

    function automatic int first_avg(int idx, int l);
        int s = 0;
        for (int j = 0; j < l; j++) s += hist[idx - j];
        return fdiv(s, l);
    endfunction

    function automatic int model_out(int l);
        int s = 0;
        for (int k = 0; k < l; k++) s += first_avg(nh - 1 - k, l);
        return fdiv(s, l);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int next_sample();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'($signed(seed[29:16]));
    endfunction

    // Drive one cycle with the given settings, then check against the model.
    task automatic push(input bit v, input int x, input int s, input int r, input string req);
        int  l;
        bit  exp_v;
        int  exp_d;
        @(negedge clk);
        in_valid   = v;
        in_data    = x[DW-1:0];
        set_code   = s[2:0];
        range_code = r[2:0];
        @(posedge clk);
        #2;
        exp_v = 1'b0;
        exp_d = last_out;
        if (eff_of(s, r) != cur_eff) begin
            cur_eff = eff_of(s, r);
            nh = 0;
        end else if (v) begin
            hist[nh] = x;
            nh++;
            l = 1 << cur_eff;
            if (nh >= 2 * l - 1) begin
                exp_v = 1'b1;
                exp_d = model_out(l);
                last_out = exp_d;
            end
        end
        chk(out_valid == exp_v, {req, " valid"}, int'(out_valid), int'(exp_v));
        chk(int'(out_data) == exp_d, {req, " data"}, int'(out_data), exp_d);
    endtask

    initial begin : watchdog
        #2_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        int l;
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
        chk(int'(out_data) == 0, "R1 data in reset", int'(out_data), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
        chk(int'(out_data) == 0, "R1 data after reset", int'(out_data), 0);

        // R3: setting 0 passes samples through unchanged
        push(1, 0, 0, 4, "R3");
        push(1, 1, 0, 4, "R3");
        push(1, -1, 0, 4, "R3");
        push(1, 8191, 0, 4, "R3");
        push(1, -8192, 0, 4, "R3");
        push(1, 1234, 0, 4, "R3");

        // R9 and R2: idle cycles hold data and give no strobe
        for (int i = 0; i < 4; i++) push(0, 777, 0, 4, "R9 R2 idle");

        // R4 and R5: every nonzero setting, with gaps in the strobe
        for (int m = 1; m <= 7; m++) begin
            l = 1 << m;
            push(0, 0, m, 4, "R7 change");
            for (int i = 0; i < 2 * l + 12; i++) begin
                if (i % 7 == 3) push(0, 0, m, 4, "R2 gap");
                else            push(1, next_sample(), m, 4, "R4 R5");
            end
        end

        // R8: full-scale constants for every setting
        for (int m = 0; m <= 7; m++) begin
            l = 1 << m;
            push(0, 0, m, 4, "R8 change");
            for (int i = 0; i < 2 * l + 1; i++) push(1, 8191, m, 4, "R8 pos");
            chk(int'(out_data) == 8191, "R8 positive full scale", int'(out_data), 8191);
            for (int i = 0; i < 2 * l - 1; i++) push(1, -8192, m, 4, "R8 neg");
            chk(int'(out_data) == -8192, "R8 negative full scale", int'(out_data), -8192);
        end

        // R6: range floors
        push(0, 0, 0, 2, "R6 mid");
        for (int i = 0; i < 12; i++) push(1, next_sample(), 0, 2, "R6 mid floor");
        push(0, 0, 1, 1, "R6 low");
        for (int i = 0; i < 40; i++) push(1, next_sample(), 1, 1, "R6 low floor");
        push(0, 0, 5, 1, "R6 above floor");
        for (int i = 0; i < 70; i++) push(1, next_sample(), 5, 1, "R6 above floor");
        push(0, 0, 0, 3, "R6 odd code");
        for (int i = 0; i < 4; i++) push(1, next_sample(), 0, 3, "R6 odd code");
        for (int i = 0; i < 4; i++) push(1, next_sample(), 0, 7, "R6 odd code");

        // R7: change with a coincident sample drops it and restarts priming
        push(0, 0, 2, 4, "R7 setup");
        for (int i = 0; i < 10; i++) push(1, next_sample(), 2, 4, "R7 primed");
        push(1, 5000, 3, 4, "R7 dropped sample");
        for (int i = 0; i < 20; i++) push(1, next_sample(), 3, 4, "R7 reprime");

        // R7: range change keeping the effective setting leaves the stream intact
        push(0, 0, 4, 4, "R7 setup");
        for (int i = 0; i < 33; i++) push(1, next_sample(), 4, 4, "R7 primed");
        for (int i = 0; i < 6; i++) push(1, next_sample(), 4, 1, "R7 same setting");
        for (int i = 0; i < 3; i++) push(0, 0, 4, 1, "R9 hold");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule